// File: doc/BRIEF.md
# Macroblock Edge Deblocking Filter

This block smooths the samples on either side of a block boundary, one line at a time. Each valid input beat carries eight unsigned 8-bit samples that straddle the boundary: four on the near side (outermost to innermost: P3, P2, P1, P0) and four on the far side (innermost to outermost: Q0, Q1, Q2, Q3). Three 8-bit thresholds come with each beat: a limit on the step across the boundary, a limit on the steps inside each side, and a threshold for high variance.

From the samples the block decides whether the line is filtered at all and whether the boundary has high variance. A high-variance line gets a short correction that touches only the two innermost samples. Any other line gets a wide correction that moves three sample pairs by decreasing fractions of one error term. The block returns the six inner samples (P2 through Q2) with a valid flag. The outermost samples are never rewritten. Addressing, transposition for vertical edges and plane packing belong to the surrounding logic.

Top module: `edge_deblock_filter`

## Requirements
- R1: A line is left unfiltered when any of |P3-P2|, |P2-P1|, |P1-P0|, |Q1-Q0|, |Q2-Q1|, |Q3-Q2| is strictly greater than the interior limit. A maximum equal to the limit still filters.
- R2: A line is left unfiltered when |P0-Q0| is strictly greater than the edge limit, compared directly with no scaling. Equality still filters.
- R3: High variance holds when max(|P1-P0|, |Q1-Q0|) is strictly greater than the variance threshold.
- R4: On a filtered high-variance line, with signed samples s = x XOR 0x80 and w = sat(sat(sat(sat(P1-Q1)+e)+e)+e), where e = sat(Q0-P0): Q0 becomes sat(Q0 - (sat(w+4)>>>3)) and P0 becomes sat(P0 + (sat(w+3)>>>3)). P2, P1, Q1 and Q2 are unchanged.
- R5: On a filtered line without high variance, a_k = sat((k*w+63)>>>7) is computed in 16-bit signed arithmetic. Each pair moves by its own a_k, subtracted from the Q sample and added to the P sample: Q0/P0 by a_27, Q1/P1 by a_18, and Q2/P2 by a_9.
- R6: Every 8-bit signed sum and difference saturates to [-128, 127] rather than wrapping, including at sample values 0 and 255.
- R7: An unfiltered line returns its six inner input samples unchanged.
- R8: The result of a line captured at clock edge k appears with outVld high right after edge k+1. There is one output beat per input beat, back-to-back beats are allowed, and outVld stays low for idle cycles.
- R9: While rstN is low, outVld is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| inVld | input | 1 | Input line valid |
| inP3 | input | 8 | Outermost near-side sample |
| inP2 | input | 8 | Near-side sample 3 from edge |
| inP1 | input | 8 | Near-side sample 2 from edge |
| inP0 | input | 8 | Near-side sample next to edge |
| inQ0 | input | 8 | Far-side sample next to edge |
| inQ1 | input | 8 | Far-side sample 2 from edge |
| inQ2 | input | 8 | Far-side sample 3 from edge |
| inQ3 | input | 8 | Outermost far-side sample |
| edgeLim | input | 8 | Limit for the step across the edge |
| interiorLim | input | 8 | Limit for steps inside each side |
| hevThr | input | 8 | High-variance threshold |
| outVld | output | 1 | Output line valid |
| outP2 | output | 8 | Filtered P2 |
| outP1 | output | 8 | Filtered P1 |
| outP0 | output | 8 | Filtered P0 |
| outQ0 | output | 8 | Filtered Q0 |
| outQ1 | output | 8 | Filtered Q1 |
| outQ2 | output | 8 | Filtered Q2 |

## Verification
The bench builds the block with its default weights of 27, 18 and 9, a rounding bias of 63 and a shift of 7. These are the only settings for which its hand-computed vectors hold, and they let an extreme step from 0 to 255 drive w to +127 and reach every saturation bound. With these values, thresholds set exactly equal to a measured step show the strict-greater comparisons. A falling edge exercises the floor behaviour of the arithmetic shift on negative products. A long random stream with idle gaps checks one output beat per input beat against an integer model.

// File: rtl/edge_deblock_pkg.sv
package edge_deblock_pkg;

  localparam int SMP_W  = 8;
  localparam int LANE_N = 8;              // P3 P2 P1 P0 Q0 Q1 Q2 Q3
  localparam int EDGE_IDX = LANE_N / 2;   // index of Q0; the edge lies below it
  localparam int MID_N  = LANE_N - 2;     // P2..Q2 are the writable lanes

  typedef logic [SMP_W-1:0]        smp_t;
  typedef logic signed [SMP_W-1:0] ssmp_t;

  localparam smp_t  SIGN_FLIP = {1'b1, {(SMP_W-1){1'b0}}};
  localparam ssmp_t S_MAX = {1'b0, {(SMP_W-1){1'b1}}};
  localparam ssmp_t S_MIN = {1'b1, {(SMP_W-1){1'b0}}};

  // Strobes from control to datapath
  typedef struct packed {
    logic capture;  // load stage-1 registers this edge
    logic commit;   // load output registers this edge
    logic filtOn;   // stage-1 line passes both limits
    logic hiVar;    // stage-1 line shows high edge variance
  } dbStrobes_t;

  function automatic ssmp_t satAdd(input ssmp_t a, input ssmp_t b);
    logic signed [SMP_W:0] s;
    s = {a[SMP_W-1], a} + {b[SMP_W-1], b};
    if (s[SMP_W] != s[SMP_W-1]) return s[SMP_W] ? S_MIN : S_MAX;
    return s[SMP_W-1:0];
  endfunction

  function automatic ssmp_t satSub(input ssmp_t a, input ssmp_t b);
    logic signed [SMP_W:0] s;
    s = {a[SMP_W-1], a} - {b[SMP_W-1], b};
    if (s[SMP_W] != s[SMP_W-1]) return s[SMP_W] ? S_MIN : S_MAX;
    return s[SMP_W-1:0];
  endfunction

  function automatic smp_t absDiff(input smp_t a, input smp_t b);
    return (a > b) ? (a - b) : (b - a);
  endfunction

endpackage

// File: rtl/edge_deblock_ctrl.sv
module edge_deblock_ctrl
  import edge_deblock_pkg::*;
(
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     inVld,
  input  smp_t [LANE_N-1:0]        smp,
  input  smp_t                     edgeLim,
  input  smp_t                     interiorLim,
  input  smp_t                     hevThr,
  output dbStrobes_t               strb,
  output logic                     outVld
);

  smp_t nbDiff [LANE_N-1];
  smp_t maxInterior;
  smp_t maxInner;
  logic filtOnNow;
  logic hiVarNow;
  logic stage1Vld;
  logic filtOnQ;
  logic hiVarQ;

  for (genvar g = 0; g < LANE_N - 1; g++) begin : g_diff
    assign nbDiff[g] = absDiff(smp[g], smp[g+1]);
  end

  always_comb begin
    maxInterior = '0;
    for (int i = 0; i < LANE_N - 1; i++) begin
      if (i != EDGE_IDX - 1 && nbDiff[i] > maxInterior) maxInterior = nbDiff[i];
    end
    maxInner  = (nbDiff[EDGE_IDX-2] > nbDiff[EDGE_IDX]) ? nbDiff[EDGE_IDX-2] : nbDiff[EDGE_IDX];
    filtOnNow = !(maxInterior > interiorLim) && !(nbDiff[EDGE_IDX-1] > edgeLim);
    hiVarNow  = maxInner > hevThr;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stage1Vld <= 1'b0;
      filtOnQ   <= 1'b0;
      hiVarQ    <= 1'b0;
      outVld    <= 1'b0;
    end else begin
      stage1Vld <= inVld;
      outVld    <= stage1Vld;
      if (inVld) begin
        filtOnQ <= filtOnNow;
        hiVarQ  <= hiVarNow;
      end
    end
  end

  assign strb = '{capture: inVld, commit: stage1Vld, filtOn: filtOnQ, hiVar: hiVarQ};

endmodule

// File: rtl/edge_deblock_dp.sv
module edge_deblock_dp
  import edge_deblock_pkg::*;
#(
  parameter int K_NEAR      = 27,
  parameter int K_MID       = 18,
  parameter int K_FAR       = 9,
  parameter int RND_BIAS    = 63,
  parameter int RND_SHIFT   = 7,
  parameter int SHORT_SHIFT = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  dbStrobes_t        strb,
  input  smp_t [MID_N-1:0]  mid,   // 0=P2 1=P1 2=P0 3=Q0 4=Q1 5=Q2
  output smp_t [MID_N-1:0]  res
);

  localparam int PROD_W = 2 * SMP_W;
  localparam int TAP_N  = MID_N / 2;
  localparam int P0_IDX = TAP_N - 1;
  localparam int Q0_IDX = TAP_N;

  ssmp_t [MID_N-1:0] sgnNow;
  ssmp_t [MID_N-1:0] sgnQ;
  ssmp_t             wNow;
  ssmp_t             wQ;
  ssmp_t             wEff;
  ssmp_t             tapAdj [TAP_N];
  ssmp_t [MID_N-1:0] nxt;

  function automatic ssmp_t baseTerm(input ssmp_t sp1, input ssmp_t sp0,
                                     input ssmp_t sq0, input ssmp_t sq1);
    ssmp_t acc;
    ssmp_t step;
    step = satSub(sq0, sp0);
    acc  = satSub(sp1, sq1);
    for (int r = 0; r < 3; r++) acc = satAdd(acc, step);
    return acc;
  endfunction

  function automatic ssmp_t shortStep(input ssmp_t w, input int bias);
    ssmp_t t;
    t = satAdd(w, ssmp_t'(bias));
    return t >>> SHORT_SHIFT;
  endfunction

  function automatic ssmp_t wideTap(input ssmp_t w, input int k);
    logic signed [PROD_W-1:0] wx;
    logic signed [PROD_W-1:0] kx;
    logic signed [PROD_W-1:0] acc;
    logic [PROD_W-SMP_W:0]    hiBits;
    wx  = PROD_W'(w);
    kx  = PROD_W'(k);
    acc = (wx * kx) + PROD_W'(RND_BIAS);
    acc = acc >>> RND_SHIFT;
    hiBits = acc[PROD_W-1:SMP_W-1];
    if (&hiBits || ~|hiBits) return acc[SMP_W-1:0];
    return acc[PROD_W-1] ? S_MIN : S_MAX;
  endfunction

  // Stage 1: signed conversion and base term
  for (genvar g = 0; g < MID_N; g++) begin : g_sign
    assign sgnNow[g] = ssmp_t'(mid[g] ^ SIGN_FLIP);
  end

  assign wNow = baseTerm(sgnNow[P0_IDX-1], sgnNow[P0_IDX], sgnNow[Q0_IDX], sgnNow[Q0_IDX+1]);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sgnQ <= '0;
      wQ   <= '0;
    end else if (strb.capture) begin
      sgnQ <= sgnNow;
      wQ   <= wNow;
    end
  end

  // Stage 2: correction
  assign wEff = strb.filtOn ? wQ : '0;

  for (genvar t = 0; t < TAP_N; t++) begin : g_tap
    localparam int K_T = (t == 0) ? K_NEAR : (t == 1) ? K_MID : K_FAR;
    assign tapAdj[t] = wideTap(wEff, K_T);
  end

  always_comb begin
    nxt = sgnQ;
    if (strb.hiVar) begin
      nxt[Q0_IDX] = satSub(sgnQ[Q0_IDX], shortStep(wEff, 4));
      nxt[P0_IDX] = satAdd(sgnQ[P0_IDX], shortStep(wEff, 3));
    end else begin
      for (int t = 0; t < TAP_N; t++) begin
        nxt[P0_IDX-t] = satAdd(sgnQ[P0_IDX-t], tapAdj[t]);
        nxt[Q0_IDX+t] = satSub(sgnQ[Q0_IDX+t], tapAdj[t]);
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      res <= '0;
    end else if (strb.commit) begin
      for (int i = 0; i < MID_N; i++) res[i] <= smp_t'(nxt[i]) ^ SIGN_FLIP;
    end
  end

endmodule

// File: rtl/edge_deblock_filter.sv
module edge_deblock_filter
  import edge_deblock_pkg::*;
#(
  parameter int K_NEAR    = 27,
  parameter int K_MID     = 18,
  parameter int K_FAR     = 9,
  parameter int RND_BIAS  = 63,
  parameter int RND_SHIFT = 7
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       inVld,
  input  logic [7:0] inP3,
  input  logic [7:0] inP2,
  input  logic [7:0] inP1,
  input  logic [7:0] inP0,
  input  logic [7:0] inQ0,
  input  logic [7:0] inQ1,
  input  logic [7:0] inQ2,
  input  logic [7:0] inQ3,
  input  logic [7:0] edgeLim,
  input  logic [7:0] interiorLim,
  input  logic [7:0] hevThr,
  output logic       outVld,
  output logic [7:0] outP2,
  output logic [7:0] outP1,
  output logic [7:0] outP0,
  output logic [7:0] outQ0,
  output logic [7:0] outQ1,
  output logic [7:0] outQ2
);

  smp_t [LANE_N-1:0] lineSmp;
  smp_t [MID_N-1:0]  lineRes;
  dbStrobes_t        strb;

  assign lineSmp = {inQ3, inQ2, inQ1, inQ0, inP0, inP1, inP2, inP3};

  edge_deblock_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .inVld       (inVld),
    .smp         (lineSmp),
    .edgeLim     (edgeLim),
    .interiorLim (interiorLim),
    .hevThr      (hevThr),
    .strb        (strb),
    .outVld      (outVld)
  );

  edge_deblock_dp #(
    .K_NEAR    (K_NEAR),
    .K_MID     (K_MID),
    .K_FAR     (K_FAR),
    .RND_BIAS  (RND_BIAS),
    .RND_SHIFT (RND_SHIFT)
  ) u_dp (
    .clk  (clk),
    .rstN (rstN),
    .strb (strb),
    .mid  (lineSmp[LANE_N-2:1]),
    .res  (lineRes)
  );

  assign outP2 = lineRes[0];
  assign outP1 = lineRes[1];
  assign outP0 = lineRes[2];
  assign outQ0 = lineRes[3];
  assign outQ1 = lineRes[4];
  assign outQ2 = lineRes[5];

endmodule

// File: rtl/edge_deblock_chk.sv
module edge_deblock_chk (
  input logic       clk,
  input logic       rstN,
  input logic       inVld,
  input logic [7:0] inP3,
  input logic [7:0] inP2,
  input logic [7:0] inP1,
  input logic [7:0] inP0,
  input logic [7:0] inQ0,
  input logic [7:0] inQ1,
  input logic [7:0] inQ2,
  input logic [7:0] inQ3,
  input logic [7:0] edgeLim,
  input logic [7:0] interiorLim,
  input logic [7:0] hevThr,
  input logic       outVld,
  input logic [7:0] outP2,
  input logic [7:0] outP1,
  input logic [7:0] outP0,
  input logic [7:0] outQ0,
  input logic [7:0] outQ1,
  input logic [7:0] outQ2
);

  logic [87:0] lineD1, lineD2;
  logic        vldD1, vldD2;
  logic [7:0]  s [8];
  logic [7:0]  eL, iL, hT;
  int          mxIn, mxHev, stepPQ;

  function automatic int ad(input logic [7:0] a, input logic [7:0] b);
    return (int'(a) > int'(b)) ? int'(a) - int'(b) : int'(b) - int'(a);
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lineD1 <= '0; lineD2 <= '0; vldD1 <= 1'b0; vldD2 <= 1'b0;
    end else begin
      lineD1 <= {inP3, inP2, inP1, inP0, inQ0, inQ1, inQ2, inQ3, edgeLim, interiorLim, hevThr};
      lineD2 <= lineD1;
      vldD1  <= inVld;
      vldD2  <= vldD1;
    end
  end

  always_comb begin
    for (int i = 0; i < 8; i++) s[i] = lineD2[87-8*i -: 8];
    eL = lineD2[23:16];
    iL = lineD2[15:8];
    hT = lineD2[7:0];
    mxIn = 0;
    for (int i = 0; i < 7; i++) if (i != 3 && ad(s[i], s[i+1]) > mxIn) mxIn = ad(s[i], s[i+1]);
    mxHev  = (ad(s[2], s[3]) > ad(s[4], s[5])) ? ad(s[2], s[3]) : ad(s[4], s[5]);
    stepPQ = ad(s[3], s[4]);
  end

  // R8
  vld_latency_chk: assert property (@(posedge clk) disable iff (!rstN) outVld == vldD2);

  // R9
  reset_quiet_chk: assert property (@(posedge clk) !rstN |=> !outVld);

  // R2
  edge_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outVld && stepPQ > int'(eL)) |->
      (outP2 == s[1] && outP1 == s[2] && outP0 == s[3] && outQ0 == s[4] && outQ1 == s[5] && outQ2 == s[6]));

  // R1
  interior_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outVld && mxIn > int'(iL)) |->
      (outP2 == s[1] && outP1 == s[2] && outP0 == s[3] && outQ0 == s[4] && outQ1 == s[5] && outQ2 == s[6]));

  // R4
  short_outer_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outVld && mxHev > int'(hT)) |->
      (outP2 == s[1] && outP1 == s[2] && outQ1 == s[5] && outQ2 == s[6]));

endmodule

bind edge_deblock_filter edge_deblock_chk u_chk (
  .clk(clk), .rstN(rstN), .inVld(inVld),
  .inP3(inP3), .inP2(inP2), .inP1(inP1), .inP0(inP0),
  .inQ0(inQ0), .inQ1(inQ1), .inQ2(inQ2), .inQ3(inQ3),
  .edgeLim(edgeLim), .interiorLim(interiorLim), .hevThr(hevThr),
  .outVld(outVld), .outP2(outP2), .outP1(outP1), .outP0(outP0),
  .outQ0(outQ0), .outQ1(outQ1), .outQ2(outQ2)
);

// File: tb/edge_deblock_filter_tb.sv
module edge_deblock_filter_tb;

  localparam int CLK_PERIOD = 10;
  localparam int VEC_N = 11;
  localparam int RAND_N = 400;

  // {P3,P2,P1,P0,Q0,Q1,Q2,Q3, edge,interior,hev, P2',P1',P0',Q0',Q1',Q2'}
  localparam logic [135:0] VEC [VEC_N] = '{
    {8'd100,8'd100,8'd100,8'd100,8'd110,8'd110,8'd110,8'd110, 8'd20,8'd5,8'd5,   8'd101,8'd103,8'd104,8'd106,8'd107,8'd109}, // R5 wide
    {8'd100,8'd100,8'd100,8'd90, 8'd100,8'd100,8'd100,8'd100, 8'd20,8'd20,8'd5,  8'd100,8'd100,8'd94, 8'd96, 8'd100,8'd100}, // R4 short
    {8'd100,8'd100,8'd100,8'd100,8'd110,8'd110,8'd110,8'd110, 8'd9, 8'd5,8'd5,   8'd100,8'd100,8'd100,8'd110,8'd110,8'd110}, // R2 off
    {8'd100,8'd100,8'd100,8'd100,8'd110,8'd110,8'd110,8'd110, 8'd10,8'd5,8'd5,   8'd101,8'd103,8'd104,8'd106,8'd107,8'd109}, // R2 equal
    {8'd105,8'd100,8'd100,8'd100,8'd110,8'd110,8'd110,8'd110, 8'd20,8'd5,8'd5,   8'd101,8'd103,8'd104,8'd106,8'd107,8'd109}, // R1 equal
    {8'd105,8'd100,8'd100,8'd100,8'd110,8'd110,8'd110,8'd110, 8'd20,8'd4,8'd5,   8'd100,8'd100,8'd100,8'd110,8'd110,8'd110}, // R1 off, R7
    {8'd100,8'd100,8'd100,8'd90, 8'd100,8'd100,8'd100,8'd100, 8'd20,8'd20,8'd10, 8'd102,8'd104,8'd96, 8'd94, 8'd96, 8'd98},  // R3 equal
    {8'd0,  8'd0,  8'd0,  8'd0,  8'd255,8'd255,8'd255,8'd255, 8'd255,8'd255,8'd0,8'd9,  8'd18, 8'd27, 8'd228,8'd237,8'd246}, // R6 wide
    {8'd110,8'd110,8'd110,8'd110,8'd100,8'd100,8'd100,8'd100, 8'd20,8'd5,8'd5,   8'd109,8'd107,8'd106,8'd104,8'd103,8'd101}, // R5 negative
    {8'd100,8'd100,8'd100,8'd90, 8'd100,8'd100,8'd100,8'd100, 8'd20,8'd20,8'd9,  8'd100,8'd100,8'd94, 8'd96, 8'd100,8'd100}, // R3 over
    {8'd0,  8'd0,  8'd255,8'd0,  8'd255,8'd0,  8'd0,  8'd0,   8'd255,8'd255,8'd0,8'd0,  8'd255,8'd15, 8'd240,8'd0,  8'd0}    // R6 short
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inVld = 1'b0;
  logic [7:0] inP3 = '0, inP2 = '0, inP1 = '0, inP0 = '0;
  logic [7:0] inQ0 = '0, inQ1 = '0, inQ2 = '0, inQ3 = '0;
  logic [7:0] edgeLim = '0, interiorLim = '0, hevThr = '0;
  logic outVld;
  logic [7:0] outP2, outP1, outP0, outQ0, outQ1, outQ2;

  int total = 0;
  int bad = 0;
  logic [47:0] expHist [RAND_N];
  logic        vldHist [RAND_N];

  always #(CLK_PERIOD/2) clk = ~clk;

  edge_deblock_filter u_dut (
    .clk(clk), .rstN(rstN), .inVld(inVld),
    .inP3(inP3), .inP2(inP2), .inP1(inP1), .inP0(inP0),
    .inQ0(inQ0), .inQ1(inQ1), .inQ2(inQ2), .inQ3(inQ3),
    .edgeLim(edgeLim), .interiorLim(interiorLim), .hevThr(hevThr),
    .outVld(outVld), .outP2(outP2), .outP1(outP1), .outP0(outP0),
    .outQ0(outQ0), .outQ1(outQ1), .outQ2(outQ2)
  );

  function automatic int iabs(input int v);
    return (v < 0) ? -v : v;
  endfunction

  function automatic int cl(input int v);
    return (v > 127) ? 127 : (v < -128) ? -128 : v;
  endfunction

  function automatic logic [47:0] model(input logic [87:0] ln);
    int x [8];
    int el, il, ht, mx, w, e, en, hv, a;
    int r [8];
    for (int i = 0; i < 8; i++) x[i] = int'(ln[87-8*i -: 8]);
    el = int'(ln[23:16]); il = int'(ln[15:8]); ht = int'(ln[7:0]);
    mx = 0;
    for (int i = 0; i < 7; i++) if (i != 3 && iabs(x[i] - x[i+1]) > mx) mx = iabs(x[i] - x[i+1]);
    en = (mx <= il) && (iabs(x[3] - x[4]) <= el);
    hv = (iabs(x[2] - x[3]) > ht) || (iabs(x[5] - x[4]) > ht);
    for (int i = 0; i < 8; i++) r[i] = x[i] - 128;
    e = cl(r[4] - r[3]);
    w = cl(r[2] - r[5]);
    w = cl(w + e); w = cl(w + e); w = cl(w + e);
    if (!en) w = 0;
    if (hv) begin
      r[4] = cl(r[4] - (cl(w + 4) >>> 3));
      r[3] = cl(r[3] + (cl(w + 3) >>> 3));
    end else begin
      a = cl((27 * w + 63) >>> 7); r[3] = cl(r[3] + a); r[4] = cl(r[4] - a);
      a = cl((18 * w + 63) >>> 7); r[2] = cl(r[2] + a); r[5] = cl(r[5] - a);
      a = cl((9 * w + 63) >>> 7);  r[1] = cl(r[1] + a); r[6] = cl(r[6] - a);
    end
    return {8'(r[1] + 128), 8'(r[2] + 128), 8'(r[3] + 128), 8'(r[4] + 128), 8'(r[5] + 128), 8'(r[6] + 128)};
  endfunction

  function automatic string tagOf(input int i);
    case (i)
      0, 8:    return "R5";
      1:       return "R4";
      2, 3:    return "R2";
      4, 5:    return "R1";
      6, 9:    return "R3";
      default: return "R6";
    endcase
  endfunction

  task automatic check(input string tag, input logic [47:0] act, input logic [47:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [87:0] ln, input logic v);
    {inP3, inP2, inP1, inP0, inQ0, inQ1, inQ2, inQ3, edgeLim, interiorLim, hevThr} = ln;
    inVld = v;
  endtask

  function automatic logic [47:0] outBus();
    return {outP2, outP1, outP0, outQ0, outQ1, outQ2};
  endfunction

  initial begin
    #(CLK_PERIOD * 100000);
    bad++;
    total++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [87:0] ln;
    // R9: held in reset
    repeat (3) @(negedge clk);
    check("R9 reset outVld", {47'd0, outVld}, 48'd0);
    check("R9 reset data", outBus(), 48'd0);
    rstN = 1'b1;

    // Table walk: each line isolated
    for (int i = 0; i < VEC_N; i++) begin
      @(negedge clk);
      drive(VEC[i][135:48], 1'b1);
      check({tagOf(i), " model"}, model(VEC[i][135:48]), VEC[i][47:0]);
      @(negedge clk);
      inVld = 1'b0;
      check("R8 not early", {47'd0, outVld}, 48'd0);
      @(negedge clk);
      check("R8 valid", {47'd0, outVld}, 48'd1);
      check(tagOf(i), outBus(), VEC[i][47:0]);
    end

    // R8 / R6 / R7: random stream with idle gaps, biased thresholds
    for (int m = 0; m < RAND_N + 2; m++) begin
      @(negedge clk);
      if (m >= 2) begin
        check("R8 stream valid", {47'd0, outVld}, {47'd0, vldHist[m-2]});
        if (vldHist[m-2]) check("R6 R7 stream data", outBus(), expHist[m-2]);
      end
      if (m < RAND_N) begin
        logic [7:0] base;
        base = 8'($urandom_range(0, 255));
        for (int k = 0; k < 8; k++) begin
          logic [7:0] sv;
          sv = (m % 3 == 0) ? 8'($urandom_range(0, 255))
                            : 8'(base + 8'($urandom_range(0, 12)) - ((k < 4) ? 8'd0 : 8'd20));
          ln[87-8*k -: 8] = sv;
        end
        ln[23:16] = 8'($urandom_range(0, 40));
        ln[15:8]  = 8'($urandom_range(0, 15));
        ln[7:0]   = 8'($urandom_range(0, 8));
        vldHist[m] = ($urandom_range(0, 4) != 0);
        expHist[m] = model(ln);
        drive(ln, vldHist[m]);
      end else begin
        inVld = 1'b0;
      end
    end

    // R9: reset while a line is in flight
    @(negedge clk);
    drive(VEC[0][135:48], 1'b1);
    @(negedge clk);
    inVld = 1'b0;
    rstN = 1'b0;
    @(negedge clk);
    check("R9 mid-run reset", {47'd0, outVld}, 48'd0);
    rstN = 1'b1;
    @(negedge clk);
    check("R9 after release", {47'd0, outVld}, 48'd0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule